// File: doc/BRIEF.md
# Shift Queue with Slot Invalidation

This block is a short in-order queue built from a chain of registers. Slot 0 is the head. Producers hand it entries over a valid/ready enqueue port, and a consumer takes them from a valid/ready dequeue port. Alongside the two handshakes, a per-slot kill mask lets surrounding logic strike any waiting entry in place, so that entry never reaches the consumer. Such logic might be a merger that has absorbed several queued requests into a single one. Surviving entries keep their arrival order.

Every slot has two flags. An occupied flag says the slot holds something, live or dead. A live flag says the entry still has to be delivered. A killed entry in the middle becomes a dead hole and moves down with the others. Dead entries at the head leave by themselves, one per cycle, whether or not the consumer is ready. Dead slots at the tail are reclaimed at once, so a new entry that arrives while the last entry is being killed takes over that slot. The queue can accept one entry and release one in the same cycle, even when it is full and even at a depth of one.

Top module: `shift_invq`

## Requirements
- R1: With the kill mask at zero, entries leave in the order they were accepted. While the head is shown and the consumer is not ready, the head stays presented and its data does not change. Once all entries are drained, the dequeue valid is low.
- R2: When enqueue valid and dequeue ready are both high, the head leaves and the new entry is taken in the same cycle. A stream of such cycles shows dequeue valid high on every cycle, with no empty gap.
- R3: Whenever dequeue valid and dequeue ready are both high, enqueue ready is high, including when the queue is full and when DEPTH is 1.
- R4: Bit i of the kill mask targets slot i, and bit 0 is the head. A mask of 2'b11 removes the two oldest entries, and neither is ever delivered.
- R5: A kill bit on the head does not lower dequeue valid in that cycle. If dequeue ready is also high, the head counts as a normal delivery.
- R6: An entry killed at the head leaves in the same cycle without dequeue ready. A dead entry that reaches the head later leaves one cycle after it arrives there, and dequeue valid is low for that one cycle. The next live entry is presented after that.
- R7: If the only remaining entry is killed in the same cycle that a new entry is accepted, the new entry takes the freed slot and is presented at the head on the next cycle.
- R8: Kill bits aimed at empty slots have no effect. Enqueue ready stays high, and the entries accepted are delivered intact and in order.
- R9: Synchronous active-high reset clears every slot. After reset, dequeue valid is low and enqueue ready is high.
- R10: When all DEPTH slots hold live entries, dequeue ready is low and the kill mask is zero, enqueue ready is low. An entry offered in that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Producer offers an entry |
| enq_ready | output | 1 | Queue can take an entry this cycle |
| enq_data | input | WIDTH | Offered entry |
| deq_valid | output | 1 | A live entry is at the head |
| deq_ready | input | 1 | Consumer takes the head |
| deq_data | output | WIDTH | Head entry |
| kill_mask | input | DEPTH | Per-slot kill request, bit 0 is the head |

## Verification
The bench checks four kill-mask corner cases.

- A kill on the head while the consumer is ready. A design that lowered valid here would create a combinational loop, or would lose the handshake and deliver the next entry twice or skip it.
- A two-entry kill followed by head draining. A design that waited for dequeue ready would stall with a dead head. A design that skipped the hole cycle would show the last entry one cycle early.
- A tail kill paired with a new arrival. A design that failed to reclaim the slot would deliver the new entry late or behind a ghost.
- Kill bits aimed at empty slots. A design that let them clear a freshly written slot would lose data.

The bench also runs a full queue under both ready polarities, and a depth-one instance passing entries straight through. A design that gated enqueue ready on "not full" alone would halve throughput there.

// File: rtl/sq_pkg.sv
package sq_pkg;

    // What happens to the head slot in the current cycle.
    typedef enum logic [1:0] {
        HEAD_NONE = 2'd0,  // nothing occupies the head after trimming
        HEAD_KEEP = 2'd1,  // live head waits for the consumer
        HEAD_SEND = 2'd2,  // live head delivered, chain shifts
        HEAD_DROP = 2'd3   // dead head discarded, chain shifts
    } head_act_e;

    typedef struct packed {
        head_act_e act;
        logic      shift;
        logic      enq_fire;
    } step_ctl_t;

    function automatic logic act_shifts(head_act_e a);
        return (a == HEAD_SEND) || (a == HEAD_DROP);
    endfunction

endpackage

// File: rtl/sq_survey.sv
// Works out which slots survive this cycle's kill mask, and which slots stay
// occupied once trailing dead slots are reclaimed.
module sq_survey #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] used,
    input  logic [DEPTH-1:0] live,
    input  logic [DEPTH-1:0] kill,
    output logic [DEPTH-1:0] survive,
    output logic [DEPTH-1:0] occ_pre
);
    logic [DEPTH-1:0] above;

    assign survive = used & live & ~kill;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            if (i == DEPTH - 1) begin : g_top
                assign above[i] = 1'b0;
            end else begin : g_mid
                assign above[i] = above[i+1] | survive[i+1];
            end
            // a dead slot is kept only if a live entry sits behind it
            assign occ_pre[i] = survive[i] | (used[i] & above[i]);
        end
    endgenerate

endmodule

// File: rtl/sq_control.sv
// Head decision, shift, enqueue readiness and the write slot.
module sq_control
    import sq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] occ_pre,
    input  logic [DEPTH-1:0] survive,
    input  logic             deq_ready,
    input  logic             enq_valid,
    output step_ctl_t        ctl,
    output logic             enq_ready,
    output logic [DEPTH-1:0] occ_post,
    output logic [DEPTH-1:0] wr_sel
);
    head_act_e act;
    logic      shift;

    always_comb begin
        if (!occ_pre[0])
            act = HEAD_NONE;
        else if (!survive[0])
            act = HEAD_DROP;
        else if (deq_ready)
            act = HEAD_SEND;
        else
            act = HEAD_KEEP;
    end

    assign shift     = act_shifts(act);
    assign enq_ready = ~occ_pre[DEPTH-1] | shift;

    assign ctl.act      = act;
    assign ctl.shift    = shift;
    assign ctl.enq_fire = enq_valid & enq_ready;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_post
            if (i == DEPTH - 1) begin : g_top
                assign occ_post[i] = shift ? 1'b0 : occ_pre[i];
            end else begin : g_mid
                assign occ_post[i] = shift ? occ_pre[i+1] : occ_pre[i];
            end
            if (i == 0) begin : g_first
                assign wr_sel[i] = ctl.enq_fire & ~occ_post[i];
            end else begin : g_rest
                assign wr_sel[i] = ctl.enq_fire & ~occ_post[i] & occ_post[i-1];
            end
        end
    endgenerate

endmodule

// File: rtl/sq_store.sv
// Register chain: per-slot occupied and live flags plus data.
module sq_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        shift,
    input  logic [DEPTH-1:0]            occ_post,
    input  logic [DEPTH-1:0]            survive,
    input  logic [DEPTH-1:0]            wr_sel,
    input  logic [WIDTH-1:0]            wr_data,
    output logic [DEPTH-1:0]            used,
    output logic [DEPTH-1:0]            live,
    output logic [DEPTH-1:0][WIDTH-1:0] data
);
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic             nxt_live;
            logic [WIDTH-1:0] nxt_data;

            if (i == DEPTH - 1) begin : g_top
                assign nxt_live = shift ? 1'b0 : survive[i];
                assign nxt_data = data[i];
            end else begin : g_mid
                assign nxt_live = shift ? survive[i+1] : survive[i];
                assign nxt_data = shift ? data[i+1] : data[i];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    used[i] <= 1'b0;
                    live[i] <= 1'b0;
                    data[i] <= '0;
                end else begin
                    used[i] <= occ_post[i] | wr_sel[i];
                    live[i] <= wr_sel[i] | nxt_live;
                    data[i] <= wr_sel[i] ? wr_data : nxt_data;
                end
            end
        end
    endgenerate

    // R7: a write never lands on a slot that stays occupied after the shift
    p_write_free_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_sel & occ_post) == '0);

endmodule

// File: rtl/shift_invq.sv
module shift_invq
    import sq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4   // at least 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    output logic             enq_ready,
    input  logic [WIDTH-1:0] enq_data,
    output logic             deq_valid,
    input  logic             deq_ready,
    output logic [WIDTH-1:0] deq_data,
    input  logic [DEPTH-1:0] kill_mask
);
    logic [DEPTH-1:0]            used;
    logic [DEPTH-1:0]            live;
    logic [DEPTH-1:0][WIDTH-1:0] data;
    logic [DEPTH-1:0]            survive;
    logic [DEPTH-1:0]            occ_pre;
    logic [DEPTH-1:0]            occ_post;
    logic [DEPTH-1:0]            wr_sel;
    step_ctl_t                   ctl;

    sq_survey #(.DEPTH(DEPTH)) u_survey (
        .used    (used),
        .live    (live),
        .kill    (kill_mask),
        .survive (survive),
        .occ_pre (occ_pre)
    );

    sq_control #(.DEPTH(DEPTH)) u_control (
        .occ_pre   (occ_pre),
        .survive   (survive),
        .deq_ready (deq_ready),
        .enq_valid (enq_valid),
        .ctl       (ctl),
        .enq_ready (enq_ready),
        .occ_post  (occ_post),
        .wr_sel    (wr_sel)
    );

    sq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .shift    (ctl.shift),
        .occ_post (occ_post),
        .survive  (survive),
        .wr_sel   (wr_sel),
        .wr_data  (enq_data),
        .used     (used),
        .live     (live),
        .data     (data)
    );

    // head validity comes from registers only, never from this cycle's mask
    assign deq_valid = live[0];
    assign deq_data  = data[0];

    // R9: reset leaves nothing to deliver
    p_reset_empty_r9: assert property (@(posedge clk)
        rst |=> !deq_valid);

    // R1: a waiting head is held steady
    p_head_hold_r1: assert property (@(posedge clk) disable iff (rst)
        deq_valid && !deq_ready && kill_mask == '0 |=> deq_valid && $stable(deq_data));

    // R3: a delivery always frees room for an arrival
    p_swap_ready_r3: assert property (@(posedge clk) disable iff (rst)
        deq_valid && deq_ready |-> enq_ready);

    // R10: full, stalled and unkilled means no room
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (&live) && !deq_ready && kill_mask == '0 |-> !enq_ready);

    // R8: an empty queue with nothing offered stays empty whatever the mask
    p_empty_stays_r8: assert property (@(posedge clk) disable iff (rst)
        used == '0 && !enq_valid |=> !deq_valid);

endmodule

// File: tb/shift_invq_tb.sv
module shift_invq_tb;
    localparam int W = 8;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    always #5 clk = ~clk;

    logic         ev = 1'b0, er, dv, dr = 1'b0;
    logic [W-1:0] ed = '0, dd;
    logic [D-1:0] km = '0;

    logic         ev1 = 1'b0, er1, dv1, dr1 = 1'b0;
    logic [W-1:0] ed1 = '0, dd1;
    logic [0:0]   km1 = '0;

    int           checks = 0;
    int           fails  = 0;
    bit           done   = 1'b0;
    logic [W-1:0] exp_q[$];

    shift_invq #(.WIDTH(W), .DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .enq_valid(ev), .enq_ready(er), .enq_data(ed),
        .deq_valid(dv), .deq_ready(dr), .deq_data(dd), .kill_mask(km));

    shift_invq #(.WIDTH(W), .DEPTH(1)) u_dut_d1 (
        .clk(clk), .rst(rst), .enq_valid(ev1), .enq_ready(er1), .enq_data(ed1),
        .deq_valid(dv1), .deq_ready(dr1), .deq_data(dd1), .kill_mask(km1));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(logic v, logic [W-1:0] d, logic r, logic [D-1:0] m);
        ev = v; ed = d; dr = r; km = m;
    endtask

    task automatic put1(logic v, logic [W-1:0] d, logic r);
        ev1 = v; ed1 = d; dr1 = r;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // scoreboard monitor: pop on delivery, push on acceptance
    always @(negedge clk) begin : mon
        logic [W-1:0] e;
        if (!rst) begin
            if (dv && dr) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R1 unexpected delivery actual=%0h expected=none", dd);
                end else begin
                    e = exp_q.pop_front();
                    chk("R1 delivery order", dd, e);
                end
            end
            if (ev && er) exp_q.push_back(ed);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9 reset state
        put(0, 0, 0, 0); #2;
        chk("R9 deq_valid after reset", dv, 0);
        chk("R9 enq_ready after reset", er, 1);
        chk("R9 depth1 deq_valid after reset", dv1, 0);
        tick();

        // R1 plain FIFO
        put(1, 8'h12, 0, 0); tick();
        put(1, 8'h34, 0, 0); tick();
        put(1, 8'h56, 0, 0); tick();
        put(0, 0, 1, 0); #2; chk("R1 head 12", dd, 8'h12); tick();
        put(0, 0, 1, 0); #2; chk("R1 head 34", dd, 8'h34); tick();
        put(1, 8'h78, 0, 0); tick();
        put(0, 0, 1, 0); tick();
        put(0, 0, 1, 0); tick();
        put(0, 0, 0, 0); #2; chk("R1 empty after drain", dv, 0); tick();

        // R2 streaming without bubbles
        put(1, 8'h12, 1, 0); tick();
        put(1, 8'h34, 1, 0); #2; chk("R2 valid while streaming", dv, 1); tick();
        put(1, 8'h56, 1, 0); #2; chk("R2 head 34 no gap", dd, 8'h34); chk("R2 valid", dv, 1); tick();
        put(0, 0, 1, 0); #2; chk("R2 head 56 no gap", dd, 8'h56); chk("R2 valid", dv, 1); tick();
        put(0, 0, 0, 0); #2; chk("R2 empty", dv, 0); tick();

        // R10 full and stalled, then R3 swap at full
        for (int k = 0; k < D; k++) begin
            put(1, 8'h20 + 8'(k), 0, 0); tick();
        end
        put(1, 8'hEE, 0, 0); #2; chk("R10 enq_ready low when full", er, 0); tick();
        put(1, 8'h99, 1, 0); #2; chk("R3 enq_ready high on swap at full", er, 1); tick();
        for (int k = 0; k < D; k++) begin
            put(0, 0, 1, 0); tick();
        end
        put(0, 0, 0, 0); #2;
        chk("R10 rejected entry never delivered", dv, 0);
        chk("R10 scoreboard drained", exp_q.size(), 0);
        tick();

        // R3 depth-one pass-through
        put1(1, 8'h12, 1); #2; chk("R3 d1 enq_ready empty", er1, 1); tick();
        put1(1, 8'h34, 1); #2; chk("R3 d1 enq_ready full swap", er1, 1); chk("R3 d1 head 12", dd1, 8'h12); tick();
        put1(1, 8'h56, 1); #2; chk("R3 d1 enq_ready full swap", er1, 1); chk("R3 d1 head 34", dd1, 8'h34); tick();
        put1(0, 0, 1); #2; chk("R3 d1 valid", dv1, 1); chk("R3 d1 head 56", dd1, 8'h56); tick();
        put1(0, 0, 0); #2; chk("R3 d1 empty", dv1, 0); tick();

        // R5 kill on head while ready: normal delivery
        put(1, 8'h12, 0, 0); tick();
        put(1, 8'h34, 0, 0); tick();
        put(0, 0, 1, 4'b0001); #2; chk("R5 valid kept under kill", dv, 1); chk("R5 head 12", dd, 8'h12); tick();
        put(0, 0, 1, 0); #2; chk("R5 next head 34", dd, 8'h34); chk("R5 valid", dv, 1); tick();
        put(0, 0, 0, 0); #2; chk("R5 empty", dv, 0); tick();

        // R4 and R6 kill two oldest, self drain
        put(1, 8'h12, 0, 0); tick();
        put(1, 8'h34, 0, 0); tick();
        put(1, 8'h56, 0, 0); tick();
        put(0, 0, 0, 4'b0011);
        void'(exp_q.pop_front());
        void'(exp_q.pop_front());
        #2; chk("R5 valid not lowered by kill", dv, 1); tick();
        put(0, 0, 0, 0); #2; chk("R6 dead head gap", dv, 0); tick();
        put(0, 0, 1, 0); #2; chk("R6 live head after drain", dv, 1); chk("R4 survivor 56", dd, 8'h56); tick();
        put(0, 0, 0, 0); #2; chk("R6 empty", dv, 0); tick();

        // R7 tail kill with arrival
        put(1, 8'h12, 0, 0); tick();
        put(1, 8'h34, 0, 4'b0001);
        void'(exp_q.pop_front());
        #2; chk("R7 enq_ready", er, 1); tick();
        put(0, 0, 1, 0); #2; chk("R7 new entry valid", dv, 1); chk("R7 new entry data", dd, 8'h34); tick();
        put(0, 0, 0, 0); #2; chk("R7 empty", dv, 0); tick();

        // R8 kill bits on empty slots
        put(1, 8'hA5, 0, 4'b1111); #2; chk("R8 enq_ready", er, 1); tick();
        put(1, 8'h5A, 0, 4'b1100); tick();
        put(0, 0, 1, 0); #2; chk("R8 first kept", dd, 8'hA5); chk("R8 valid", dv, 1); tick();
        put(0, 0, 1, 0); #2; chk("R8 second kept", dd, 8'h5A); tick();
        put(0, 0, 0, 0); #2;
        chk("R8 empty", dv, 0);
        chk("R1 scoreboard drained", exp_q.size(), 0);
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule